// File: doc/BRIEF.md
# Run-time configurable CIC decimation filter

This block turns a one-bit oversampled bitstream into signed 16-bit words. It watches a modulator clock that arrives as an ordinary level on a system-clock input. On each qualifying modulator-clock edge it takes one bit, maps it to +1 or -1 and feeds it through a cascade of integrators. Every N taken samples a matching cascade of comb sections produces one decimated value. The number of cascaded stages (one, two or three) and the decimation ratio N are inputs, so firmware can trade resolution against response time without re-synthesis.

Each decimated value is shifted right by an amount derived from the stage count and N, so that the largest possible magnitude fits the 16-bit word. A signed offset is then subtracted and the difference is saturated. A preload value for the decimation counter lets several filters be run out of phase with one another. A trigger input snapshots the current result, the decimation counter and a running result count together, which lets software work out the age of the last result.

Top module: `cic_decimator`

## Requirements
- R1: With `dbl_mode` low, one sample is taken for every rising edge of `mod_clk`. A rising edge is seen at a system-clock edge where `mod_clk` is 1 and was 0 at the previous system-clock edge. The bit is the value of `bit_in` at that same system-clock edge.
- R2: With `dbl_mode` high, samples are taken on falling edges of `mod_clk`. The first falling edge after a clear is skipped, and after that every second falling edge is taken. This gives one sample per two modulator periods.
- R3: A sampled 1 enters the first integrator as +1 and a sampled 0 enters as -1. `order_sel` codes 1, 2 and 3 select that many integrator and comb stages, and code 0 acts as 1. Before scaling, each output equals the integrator/comb cascade value, computed with comb delay registers that start at zero after a clear.
- R4: `dec_factor` (4 to 256) sets the number of samples per output. A clear loads the decimation counter with `start_val` (which must be below `dec_factor`). The counter advances once per sample and wraps to 0 when it reaches `dec_factor`-1, and each wrap produces one output. The first output after a clear therefore comes after `dec_factor`-`start_val` samples.
- R5: Let g = stages × ceil(log2(`dec_factor`)). Each cascade output is arithmetically shifted right by g-15 bits when g > 15, and is not shifted otherwise. The shifted magnitude never exceeds 32768.
- R6: The signed `offset` is subtracted after the shift. The difference is saturated to the range -32768 to 32767 and then stored in `result`.
- R7: `result` and `result_valid` change on the third system-clock edge, counted from the edge that takes the sample completing a window. `result_valid` is high for exactly that one cycle.
- R8: While `clr` is high at a clock edge, all integrators, comb delays and pending outputs are cleared, the sampling phase is reset and the counter is reloaded. No output appears until a full new window has been taken. `result` keeps its last value.
- R9: A trigger edge is seen when `trig_in` differs from its value at the previous system-clock edge in the selected direction: rising when `trig_fall` = 0, falling when `trig_fall` = 1. At that edge, `ts_result`, `ts_dcount` and `ts_rcount` capture the pre-edge `result`, decimation counter and result count. A result written at the same edge is not captured.
- R10: The result count is 8 bits wide. It increments on each `result_valid`, wraps modulo 256, and is zeroed by a clear.
- R11: With three stages and `dec_factor` = 32, a constant-1 stream settles to 32767 (a full scale of +32768, saturated) and a constant-0 stream settles to -32768, both with zero offset.
- R12: During reset, `result`, `result_valid` and all timestamp outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous filter clear |
| mod_clk | input | 1 | Modulator clock level |
| bit_in | input | 1 | Bitstream data |
| dbl_mode | input | 1 | 0: rising-edge sampling, 1: every second falling edge |
| order_sel | input | 2 | Number of cascade stages (0 acts as 1) |
| dec_factor | input | 9 | Decimation ratio, 4 to 256 |
| start_val | input | 9 | Decimation counter preload |
| offset | input | 16 | Signed value subtracted after scaling |
| trig_in | input | 1 | Timestamp trigger |
| trig_fall | input | 1 | 0: capture on rising trigger, 1: on falling |
| result | output | 16 | Signed filtered word |
| result_valid | output | 1 | One-cycle pulse when `result` is written |
| ts_result | output | 16 | Captured result |
| ts_dcount | output | 9 | Captured decimation counter |
| ts_rcount | output | 8 | Captured result count |

## Verification
The delicate overlap is a trigger edge that lands on the same system-clock edge as a result write. The bench uses its own behavioural model to find the edge on which a write is pending, and raises `trig_in` just before that edge. It then expects `ts_result` to hold the word from before the write while `result_valid` is high with the new word. A second overlap is a clear that arrives with an output pending in the pipeline. The random runs cover this, and the cycle-by-cycle comparison against the model checks both that the pulse is dropped and that the count is zeroed.

// File: rtl/cicd_pkg.sv
package cicd_pkg;
  localparam int RES_W = 16;

  // stage count from the order code; code 0 behaves as a single stage
  function automatic int stage_count(input logic [1:0] code);
    return (code == 2'd0) ? 1 : int'(code);
  endfunction

  function automatic int ceil_log2(input int n);
    int lg;
    lg = 0;
    for (int i = 0; i < 16; i++) begin
      if ((1 << i) < n) lg = i + 1;
    end
    return lg;
  endfunction

  // right shift that keeps the worst-case cascade output within 16 bits
  function automatic logic [4:0] scale_shift(input logic [1:0] code, input int n);
    int g;
    g = stage_count(code) * ceil_log2(n);
    return (g > RES_W - 1) ? 5'(g - (RES_W - 1)) : 5'd0;
  endfunction

  function automatic logic signed [15:0] clamp16(input logic signed [31:0] v);
    if (v > 32'sd32767) return 16'sh7fff;
    if (v < -32'sd32768) return 16'sh8000;
    return v[15:0];
  endfunction
endpackage

// File: rtl/cicd_sampler.sv
module cicd_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic mod_clk,
  input  logic bit_in,
  input  logic dbl_mode,
  output logic smp_stb,
  output logic smp_bit
);
  logic mclk_q, half_q;
  logic rise_w, fall_w, take_w;

  assign rise_w = mod_clk & ~mclk_q;
  assign fall_w = ~mod_clk & mclk_q;
  assign take_w = dbl_mode ? (fall_w & half_q) : rise_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mclk_q  <= 1'b0;
      half_q  <= 1'b0;
      smp_stb <= 1'b0;
      smp_bit <= 1'b0;
    end else begin
      mclk_q  <= mod_clk;
      smp_bit <= bit_in;
      if (clr) begin
        half_q  <= 1'b0;
        smp_stb <= 1'b0;
      end else begin
        smp_stb <= take_w;
        if (dbl_mode && fall_w) half_q <= ~half_q;
      end
    end
  end

  // R1
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> !smp_stb);
endmodule

// File: rtl/cicd_core.sv
module cicd_core #(
  parameter int STG  = 3,
  parameter int DCW  = 9,
  parameter int ACCW = 26
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   smp_stb,
  input  logic                   smp_bit,
  input  logic [1:0]             order_sel,
  input  logic [DCW-1:0]         dec_factor,
  input  logic [DCW-1:0]         start_val,
  output logic signed [ACCW-1:0] raw_q,
  output logic                   raw_vld,
  output logic [DCW-1:0]         dcnt_q,
  output logic                   tick
);
  localparam int IDXW = (STG > 1) ? $clog2(STG) : 1;

  logic signed [ACCW-1:0] acc_q   [STG];
  logic signed [ACCW-1:0] dly_q   [STG];
  logic signed [ACCW-1:0] integ_n [STG];
  logic signed [ACCW-1:0] comb_n  [STG];
  logic signed [ACCW-1:0] inc_w, tap_w, out_w;
  logic [IDXW-1:0]        tap_idx;

  // +1 for a one, -1 for a zero
  assign inc_w = {{(ACCW-1){~smp_bit}}, 1'b1};
  assign tick  = smp_stb & ~clr & (dcnt_q >= dec_factor - 1'b1);

  always_comb begin
    int sel_i;
    sel_i = cicd_pkg::stage_count(order_sel) - 1;
    if (sel_i > STG - 1) sel_i = STG - 1;
    tap_idx = IDXW'(sel_i);
    integ_n[0] = acc_q[0] + inc_w;
    for (int s = 1; s < STG; s++) integ_n[s] = acc_q[s] + integ_n[s-1];
    tap_w = integ_n[tap_idx];
    comb_n[0] = tap_w - dly_q[0];
    for (int s = 1; s < STG; s++) comb_n[s] = comb_n[s-1] - dly_q[s];
    out_w = comb_n[tap_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STG; s++) begin
        acc_q[s] <= '0;
        dly_q[s] <= '0;
      end
      dcnt_q  <= '0;
      raw_q   <= '0;
      raw_vld <= 1'b0;
    end else if (clr) begin
      for (int s = 0; s < STG; s++) begin
        acc_q[s] <= '0;
        dly_q[s] <= '0;
      end
      dcnt_q  <= start_val;
      raw_vld <= 1'b0;
    end else begin
      raw_vld <= tick;
      if (smp_stb) begin
        for (int s = 0; s < STG; s++) acc_q[s] <= integ_n[s];
        dcnt_q <= tick ? '0 : dcnt_q + 1'b1;
      end
      if (tick) begin
        dly_q[0] <= tap_w;
        for (int s = 1; s < STG; s++) dly_q[s] <= comb_n[s-1];
        raw_q <= out_w;
      end
    end
  end

  // R4
  dec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (dcnt_q == '0) && raw_vld);
endmodule

// File: rtl/cicd_result.sv
module cicd_result #(
  parameter int DCW  = 9,
  parameter int ACCW = 26,
  parameter int RCW  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic signed [ACCW-1:0] raw_q,
  input  logic                   raw_vld,
  input  logic [1:0]             order_sel,
  input  logic [DCW-1:0]         dec_factor,
  input  logic signed [15:0]     offset,
  output logic signed [15:0]     result,
  output logic                   result_valid,
  output logic [RCW-1:0]         rcnt_q
);
  localparam logic signed [ACCW-1:0] LIM = ACCW'(32768);

  logic [4:0]             shamt_w;
  logic signed [ACCW-1:0] shifted_w;
  logic signed [31:0]     diff_w;

  assign shamt_w   = cicd_pkg::scale_shift(order_sel, int'(dec_factor));
  assign shifted_w = raw_q >>> shamt_w;
  assign diff_w    = 32'(shifted_w) - 32'(offset);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result       <= '0;
      result_valid <= 1'b0;
      rcnt_q       <= '0;
    end else if (clr) begin
      result_valid <= 1'b0;
      rcnt_q       <= '0;
    end else begin
      result_valid <= raw_vld;
      if (raw_vld) begin
        result <= cicd_pkg::clamp16(diff_w);
        rcnt_q <= rcnt_q + 1'b1;
      end
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_vld |-> (shifted_w <= LIM) && (shifted_w >= -LIM));
  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_vld && !clr) |=> result_valid);
endmodule

// File: rtl/cicd_stamp.sv
module cicd_stamp #(
  parameter int DCW = 9,
  parameter int RCW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_in,
  input  logic               trig_fall,
  input  logic signed [15:0] result,
  input  logic [DCW-1:0]     dcnt,
  input  logic [RCW-1:0]     rcnt,
  output logic signed [15:0] ts_result,
  output logic [DCW-1:0]     ts_dcount,
  output logic [RCW-1:0]     ts_rcount
);
  logic trig_q, trig_edge_w;

  assign trig_edge_w = trig_fall ? (~trig_in & trig_q) : (trig_in & ~trig_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q    <= 1'b0;
      ts_result <= '0;
      ts_dcount <= '0;
      ts_rcount <= '0;
    end else begin
      trig_q <= trig_in;
      if (trig_edge_w) begin
        ts_result <= result;
        ts_dcount <= dcnt;
        ts_rcount <= rcnt;
      end
    end
  end

  // R9
  ts_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_edge_w |=> (ts_result == $past(result)) && (ts_rcount == $past(rcnt)));
endmodule

// File: rtl/cic_decimator.sv
module cic_decimator #(
  parameter int MAXN = 256,
  parameter int STG  = 3,
  parameter int RCW  = 8,
  localparam int DCW  = $clog2(MAXN + 1),
  localparam int ACCW = STG * $clog2(MAXN) + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               mod_clk,
  input  logic               bit_in,
  input  logic               dbl_mode,
  input  logic [1:0]         order_sel,
  input  logic [DCW-1:0]     dec_factor,
  input  logic [DCW-1:0]     start_val,
  input  logic signed [15:0] offset,
  input  logic               trig_in,
  input  logic               trig_fall,
  output logic signed [15:0] result,
  output logic               result_valid,
  output logic signed [15:0] ts_result,
  output logic [DCW-1:0]     ts_dcount,
  output logic [RCW-1:0]     ts_rcount
);
  logic                   smp_stb, smp_bit;
  logic signed [ACCW-1:0] raw_q;
  logic                   raw_vld, tick;
  logic [DCW-1:0]         dcnt_q;
  logic [RCW-1:0]         rcnt_q;

  cicd_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mod_clk(mod_clk), .bit_in(bit_in),
    .dbl_mode(dbl_mode), .smp_stb(smp_stb), .smp_bit(smp_bit)
  );

  cicd_core #(.STG(STG), .DCW(DCW), .ACCW(ACCW)) u_core (
    .clk(clk), .rst_n(rst_n), .clr(clr), .smp_stb(smp_stb), .smp_bit(smp_bit),
    .order_sel(order_sel), .dec_factor(dec_factor), .start_val(start_val),
    .raw_q(raw_q), .raw_vld(raw_vld), .dcnt_q(dcnt_q), .tick(tick)
  );

  cicd_result #(.DCW(DCW), .ACCW(ACCW), .RCW(RCW)) u_res (
    .clk(clk), .rst_n(rst_n), .clr(clr), .raw_q(raw_q), .raw_vld(raw_vld),
    .order_sel(order_sel), .dec_factor(dec_factor), .offset(offset),
    .result(result), .result_valid(result_valid), .rcnt_q(rcnt_q)
  );

  cicd_stamp #(.DCW(DCW), .RCW(RCW)) u_ts (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_fall(trig_fall),
    .result(result), .dcnt(dcnt_q), .rcnt(rcnt_q),
    .ts_result(ts_result), .ts_dcount(ts_dcount), .ts_rcount(ts_rcount)
  );

  // R8
  clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !result_valid && (dcnt_q == $past(start_val)));
endmodule

// File: tb/cic_decimator_test.sv
module cic_decimator_test;
  logic clk = 0, rst_n = 0, clr = 0, mod_clk = 0, bit_in = 0, dbl_mode = 0;
  logic [1:0] order_sel = 2'd3;
  logic [8:0] dec_factor = 9'd32, start_val = 9'd0;
  logic signed [15:0] offset = 0;
  logic trig_in = 0, trig_fall = 0;
  logic signed [15:0] result, ts_result;
  logic result_valid;
  logic [8:0] ts_dcount;
  logic [7:0] ts_rcount;

  cic_decimator uut (.*);

  always #2 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit cmp_en = 0, mc_run = 1;
  int hc = 0, rise_cnt = 0, fall_cnt = 0, pat = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // stimulus sources
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    bit_in = (pat == 0) ? 1'b0 : (pat == 1) ? 1'b1 : lfsr[0];
    if (mc_run) begin
      hc++;
      if (hc == 3) begin
        hc = 0;
        mod_clk = ~mod_clk;
        if (mod_clk) rise_cnt++; else fall_cnt++;
      end
    end
  end

  // behavioural reference, evaluated at each rising edge
  bit m_mq, m_tq, m_phase, m_stb, m_bit, m_rawv, m_rv;
  longint i1, i2, i3, d1, d2, d3, m_raw;
  int m_dcnt, m_res, m_rcnt, m_tsr, m_tsd, m_tsc;

  function automatic int ref_post(longint raw, int k, int n, int off);
    int lg = 0;
    int s;
    longint v = raw;
    while ((1 << lg) < n) lg++;
    s = k * lg - 15;
    for (int j = 0; j < s; j++) v = (v < 0 && (v % 2) != 0) ? (v - 1) / 2 : v / 2;
    v = v - off;
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return int'(v);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mq = 0; m_tq = 0; m_phase = 0; m_stb = 0; m_bit = 0; m_rawv = 0; m_rv = 0;
      i1 = 0; i2 = 0; i3 = 0; d1 = 0; d2 = 0; d3 = 0; m_raw = 0;
      m_dcnt = 0; m_res = 0; m_rcnt = 0; m_tsr = 0; m_tsd = 0; m_tsc = 0;
    end else begin
      int k;
      longint y, c1, c2, c3;
      k = (order_sel == 0) ? 1 : int'(order_sel);
      if (trig_fall ? (!trig_in && m_tq) : (trig_in && !m_tq)) begin
        m_tsr = m_res; m_tsd = m_dcnt; m_tsc = m_rcnt;
      end
      m_tq = trig_in;
      if (clr) begin
        m_rv = 0; m_rcnt = 0;
      end else if (m_rawv) begin
        m_res = ref_post(m_raw, k, int'(dec_factor), int'(offset));
        m_rv = 1; m_rcnt = (m_rcnt + 1) % 256;
      end else m_rv = 0;
      if (clr) begin
        i1 = 0; i2 = 0; i3 = 0; d1 = 0; d2 = 0; d3 = 0;
        m_dcnt = int'(start_val); m_rawv = 0;
      end else if (m_stb) begin
        i1 += m_bit ? 1 : -1; i2 += i1; i3 += i2;
        if (m_dcnt >= int'(dec_factor) - 1) begin
          y = (k == 1) ? i1 : (k == 2) ? i2 : i3;
          c1 = y - d1; c2 = c1 - d2; c3 = c2 - d3;
          d1 = y; d2 = c1; d3 = c2;
          m_raw = (k == 1) ? c1 : (k == 2) ? c2 : c3;
          m_rawv = 1; m_dcnt = 0;
        end else begin
          m_dcnt++; m_rawv = 0;
        end
      end else m_rawv = 0;
      if (clr) begin
        m_stb = 0; m_phase = 0;
      end else if (dbl_mode) begin
        m_stb = (!mod_clk && m_mq) && m_phase;
        if (!mod_clk && m_mq) m_phase = !m_phase;
      end else m_stb = mod_clk && !m_mq;
      m_bit = bit_in;
      m_mq = mod_clk;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      check("R3 R5 R6 result vs model", result, m_res);
      check("R7 result_valid vs model", result_valid, m_rv);
      check("R9 ts_result vs model", ts_result, m_tsr);
      check("R9 ts_dcount vs model", ts_dcount, m_tsd);
      check("R10 ts_rcount vs model", ts_rcount, m_tsc);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      finish_up();
    end
  end

  task automatic setup(input int k, input int n, input int st, input int off, input bit dbl);
    @(negedge clk);
    order_sel = 2'(k); dec_factor = 9'(n); start_val = 9'(st);
    offset = 16'(off); dbl_mode = dbl;
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  task automatic wait_results(input int n);
    int got = 0;
    while (got < n) begin
      @(negedge clk);
      if (result_valid) got++;
    end
  endtask

  task automatic restart_clear();
    while (mod_clk) @(negedge clk);
    mc_run = 0;
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    rise_cnt = 0; fall_cnt = 0; hc = 0;
    mc_run = 1;
  endtask

  task automatic pulse_trig();
    trig_in = 1;
    @(negedge clk); trig_in = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12
    check("R12 reset result", result, 0);
    check("R12 reset valid", result_valid, 0);
    check("R12 reset ts_result", ts_result, 0);
    check("R12 reset ts_rcount", ts_rcount, 0);
    rst_n = 1;
    cmp_en = 1;

    // R11 full scale, three stages, N = 32
    setup(3, 32, 0, 0, 0); pat = 1; wait_results(4);
    check("R11 ones full scale", result, 32767);
    pat = 0; wait_results(4);
    check("R11 zeros full scale", result, -32768);

    // R3 single stage, and code 0 acting as one stage
    setup(1, 4, 0, 0, 0); pat = 1; wait_results(2);
    check("R3 one stage ones", result, 4);
    setup(0, 4, 0, 0, 0); pat = 0; wait_results(2);
    check("R3 code0 zeros", result, -4);
    setup(2, 16, 0, 0, 0); pat = 1; wait_results(3);
    check("R3 two stage ones", result, 256);

    // R5 shift, R6 offset and saturation
    setup(2, 200, 0, 0, 0); pat = 1; wait_results(3);
    check("R5 shifted two stage N200", result, 20000);
    setup(2, 200, 0, 1000, 0); wait_results(3);
    check("R6 offset positive", result, 19000);
    setup(2, 200, 0, -5000, 0); pat = 0; wait_results(3);
    check("R6 offset negative", result, -15000);
    setup(3, 32, 0, 100, 0); pat = 0; wait_results(4);
    check("R6 negative saturation", result, -32768);

    // R1 and R4: first output after N - start rising edges
    setup(1, 32, 20, 0, 0); pat = 2;
    restart_clear();
    while (!result_valid) @(negedge clk);
    check("R4 R1 samples to first output", rise_cnt, 12);

    // R2: double mode needs 2N falling edges for the first output
    setup(1, 4, 0, 0, 1); pat = 1;
    restart_clear();
    while (!result_valid) @(negedge clk);
    check("R2 falling edges to first output", fall_cnt, 8);
    check("R2 double mode value", result, 4);

    // R10 result count, then R8 clear
    setup(2, 16, 0, 0, 0); pat = 2; wait_results(5);
    pulse_trig();
    check("R10 count after five", ts_rcount, 5);
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    pulse_trig();
    check("R8 count zero after clear", ts_rcount, 0);
    begin
      int seen = 0;
      repeat (40) begin
        @(negedge clk);
        if (result_valid) seen++;
      end
      check("R8 no output inside first window", seen, 0);
    end

    // R9 trigger edge landing on a result write
    wait_results(2);
    while (!m_rawv) @(negedge clk);
    begin
      int old_res;
      old_res = int'(result);
      trig_in = 1;
      @(negedge clk); trig_in = 0;
      check("R9 collision valid high", result_valid, 1);
      check("R9 collision captures old result", ts_result, old_res);
    end

    // random runs across modes
    setup(3, 256, 0, 1310, 0); wait_results(3);
    setup(1, 5, 0, -7, 0); wait_results(6);
    trig_fall = 1;
    setup(3, 8, 3, 12, 1);
    repeat (600) begin
      @(negedge clk);
      trig_in = lfsr[5];
    end
    trig_fall = 0; trig_in = 0;
    setup(2, 100, 50, 0, 0); wait_results(3);
    // clear arriving with outputs in flight
    repeat (30) begin
      setup(1, 4, 1, 0, 0);
      repeat (7) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule